// File: doc/BRIEF.md
# Six-bit minifloat to fixed-point converter

This block takes a six-bit floating-point code and turns it into a signed fixed-point number in sixteenths. Bit 5 of the code is the sign, bits 4:2 hold a biased exponent (bias 3) and bits 1:0 hold a fraction. With this format every finite code maps exactly onto a multiple of 1/16, so no rounding is needed. Codes below the normal range, which have no hidden one, also convert exactly.

Each conversion is requested with a valid strobe. The result appears one clock later in a register, together with a flag for infinity, a flag for not-a-number and an output strobe. While no request is present, the register keeps its last value. A surrounding datapath can therefore sample the result at any time after the strobe.

Top module: `mf2fx`

## Requirements
- R1: An exponent field of 000 is a denormal. Its magnitude in 1/16 units equals the fraction field, so code 0 000 01 gives 1 and code 0 000 11 gives 3.
- R2: An exponent field e from 001 to 110 is normal. Its magnitude in 1/16 units is (4 + frac) × 2^(e−1). Code 0 011 01 gives 20, code 0 110 10 gives 192 and code 0 001 00 gives 4.
- R3: The largest finite code, 0 110 11, gives 224. For every code that is not an infinity, the absolute value of the result never exceeds 224.
- R4: Exponent 111 with fraction 00 sets the infinity flag and clears the NaN flag. The result saturates to +255, or to −255 when the sign bit is 1.
- R5: Exponent 111 with a nonzero fraction sets the NaN flag, clears the infinity flag and forces the result to 0 whatever the sign bit is.
- R6: When the sign bit is 1, the result is the 9-bit two's-complement negative of the magnitude. Negative zero (1 000 00) gives 0.
- R7: The result and flags change at the first rising clock edge where the input strobe is high. The output strobe is high for exactly the cycle after each cycle in which the input strobe is high, and low otherwise.
- R8: When the input strobe is low, changes on the code input have no effect: the result and both flags keep their values.
- R9: A synchronous reset clears the result, both flags and the output strobe to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Conversion request strobe |
| in_code | input | 6 | Code: [5] sign, [4:2] exponent, [1:0] fraction |
| out_vld | output | 1 | High one cycle after a request |
| out_fx | output | 9 | Signed result in units of 1/16 |
| out_inf | output | 1 | Infinity flag of the last conversion |
| out_nan | output | 1 | NaN flag of the last conversion |

## Verification
The hardest case to observe from the ports is the hold behaviour. A stale result looks exactly like a fresh one unless the code under the dropped strobe would convert to a different value. The stimulus therefore loads a known conversion, then drives a code with a different value while the strobe stays low for several clocks, and expects the old result. The sign handling at zero and at the specials is also easy to miss. For that reason, negative zero, negative infinity and negative NaN codes are each sent on their own.

// File: rtl/mf2fx_pkg.sv
package mf2fx_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_NAN    = 3'd4
    } fp_class_e;

endpackage

// File: rtl/mf2fx_classify.sv
module mf2fx_classify #(
    parameter int EXP_W  = 3,
    parameter int FRAC_W = 2,
    localparam int CODE_W = 1 + EXP_W + FRAC_W
) (
    input  logic [CODE_W-1:0]     code_i,
    output logic                  sign_o,
    output logic [EXP_W-1:0]      exp_o,
    output logic [FRAC_W-1:0]     frac_o,
    output mf2fx_pkg::fp_class_e  cls_o
);
    import mf2fx_pkg::*;

    always_comb begin
        sign_o = code_i[CODE_W-1];
        exp_o  = code_i[FRAC_W +: EXP_W];
        frac_o = code_i[FRAC_W-1:0];
        if (&exp_o) begin
            cls_o = (|frac_o) ? CLS_NAN : CLS_INF;
        end else if (~|exp_o) begin
            cls_o = (|frac_o) ? CLS_DENORM : CLS_ZERO;
        end else begin
            cls_o = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/mf2fx_magnitude.sv
module mf2fx_magnitude #(
    parameter int EXP_W  = 3,
    parameter int FRAC_W = 2,
    localparam int MAG_W = FRAC_W + (1 << EXP_W) - 2
) (
    input  logic [EXP_W-1:0]      exp_i,
    input  logic [FRAC_W-1:0]     frac_i,
    input  mf2fx_pkg::fp_class_e  cls_i,
    output logic [MAG_W-1:0]      mag_o
);
    import mf2fx_pkg::*;

    logic [MAG_W-1:0] sig_ext;
    logic [EXP_W-1:0] shamt;

    always_comb begin
        sig_ext = MAG_W'({1'b1, frac_i});
        shamt   = exp_i - EXP_W'(1);
        unique case (cls_i)
            CLS_DENORM: mag_o = MAG_W'(frac_i);
            CLS_NORMAL: mag_o = sig_ext << shamt;
            CLS_INF:    mag_o = '1;
            default:    mag_o = '0;
        endcase
    end

endmodule

// File: rtl/mf2fx_negate.sv
module mf2fx_negate #(
    parameter int MAG_W = 8,
    localparam int OUT_W = MAG_W + 1
) (
    input  logic                    neg_i,
    input  logic [MAG_W-1:0]        mag_i,
    output logic signed [OUT_W-1:0] fx_o
);
    logic [OUT_W-1:0] ext;

    always_comb begin
        ext  = {1'b0, mag_i};
        fx_o = neg_i ? $signed(~ext + OUT_W'(1)) : $signed(ext);
    end

endmodule

// File: rtl/mf2fx.sv
module mf2fx #(
    parameter int EXP_W  = 3,
    parameter int FRAC_W = 2,
    localparam int CODE_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = FRAC_W + (1 << EXP_W) - 2,
    localparam int OUT_W  = MAG_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [CODE_W-1:0]       in_code,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_fx,
    output logic                    out_inf,
    output logic                    out_nan
);
    import mf2fx_pkg::*;

    typedef struct packed {
        logic signed [OUT_W-1:0] fx;
        logic                    inf;
        logic                    nan;
        logic                    vld;
    } conv_state_t;

    conv_state_t st_d, st_q;

    logic                    sign_w;
    logic [EXP_W-1:0]        exp_w;
    logic [FRAC_W-1:0]       frac_w;
    fp_class_e               cls_w;
    logic [MAG_W-1:0]        mag_w;
    logic signed [OUT_W-1:0] fx_w;

    mf2fx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .code_i (in_code),
        .sign_o (sign_w),
        .exp_o  (exp_w),
        .frac_o (frac_w),
        .cls_o  (cls_w)
    );

    mf2fx_magnitude #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_magnitude (
        .exp_i  (exp_w),
        .frac_i (frac_w),
        .cls_i  (cls_w),
        .mag_o  (mag_w)
    );

    mf2fx_negate #(.MAG_W(MAG_W)) u_negate (
        .neg_i (sign_w),
        .mag_i (mag_w),
        .fx_o  (fx_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.fx  = fx_w;
            st_d.inf = (cls_w == CLS_INF);
            st_d.nan = (cls_w == CLS_NAN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_fx  = st_q.fx;
    assign out_inf = st_q.inf;
    assign out_nan = st_q.nan;

endmodule

// File: rtl/mf2fx_chk.sv
module mf2fx_chk #(
    parameter int EXP_W  = 3,
    parameter int FRAC_W = 2,
    localparam int MAG_W   = FRAC_W + (1 << EXP_W) - 2,
    localparam int OUT_W   = MAG_W + 1,
    localparam int MAX_FIN = ((1 << (FRAC_W + 1)) - 1) << ((1 << EXP_W) - 3),
    localparam int SAT     = (1 << MAG_W) - 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_vld,
    input logic                    out_vld,
    input logic signed [OUT_W-1:0] out_fx,
    input logic                    out_inf,
    input logic                    out_nan
);

    p_vld_rise_r7: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    p_vld_low_r7: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_fx) && $stable(out_inf) && $stable(out_nan)));

    p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({out_inf, out_nan}) <= 1);

    p_nan_zero_r5: assert property (@(posedge clk) disable iff (rst)
        out_nan |-> (out_fx == '0));

    p_inf_sat_r4: assert property (@(posedge clk) disable iff (rst)
        out_inf |-> ((int'(out_fx) == SAT) || (int'(out_fx) == -SAT)));

    p_fin_range_r3: assert property (@(posedge clk) disable iff (rst)
        !out_inf |-> ((int'(out_fx) <= MAX_FIN) && (int'(out_fx) >= -MAX_FIN)));

endmodule

bind mf2fx mf2fx_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_fx  (out_fx),
    .out_inf (out_inf),
    .out_nan (out_nan)
);

// File: tb/mf2fx_tb.sv
module mf2fx_tb;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_vld = 1'b0;
    logic [5:0]        in_code = '0;
    logic              out_vld;
    logic signed [8:0] out_fx;
    logic              out_inf;
    logic              out_nan;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    mf2fx u_dut (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_code (in_code),
        .out_vld (out_vld),
        .out_fx  (out_fx),
        .out_inf (out_inf),
        .out_nan (out_nan)
    );

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int ref_fx(input logic [5:0] c);
        int e, f, m;
        e = int'(c[4:2]);
        f = int'(c[1:0]);
        if (e == 7)      m = (f == 0) ? 255 : 0;
        else if (e == 0) m = f;
        else             m = (4 + f) * (1 << (e - 1));
        return c[5] ? -m : m;
    endfunction

    task automatic send(input logic [5:0] c);
        @(negedge clk);
        in_code = c;
        in_vld  = 1'b1;
        @(negedge clk);
        in_vld  = 1'b0;
    endtask

    task automatic conv_chk(input string req, input logic [5:0] c, input int expv,
                            input int exp_inf, input int exp_nan);
        send(c);
        chk(req, "value", int'(out_fx), expv);
        chk(req, "inf flag", int'(out_inf), exp_inf);
        chk(req, "nan flag", int'(out_nan), exp_nan);
        chk(req, "out_vld", int'(out_vld), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_vld = 1'b1;
        in_code = 6'b0_110_11;
        repeat (3) @(negedge clk);
        chk("R9", "fx in reset", int'(out_fx), 0);
        chk("R9", "vld in reset", int'(out_vld), 0);
        chk("R9", "inf in reset", int'(out_inf), 0);
        chk("R9", "nan in reset", int'(out_nan), 0);
        in_vld = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_denorm();
        conv_chk("R1", 6'b0_000_01, 1, 0, 0);
        conv_chk("R1", 6'b0_000_10, 2, 0, 0);
        conv_chk("R1", 6'b0_000_11, 3, 0, 0);
        conv_chk("R1", 6'b0_000_00, 0, 0, 0);
    endtask

    task automatic t_normal();
        conv_chk("R2", 6'b0_001_00, 4, 0, 0);
        conv_chk("R2", 6'b0_011_01, 20, 0, 0);
        conv_chk("R2", 6'b0_110_10, 192, 0, 0);
        conv_chk("R2", 6'b0_010_11, 14, 0, 0);
    endtask

    task automatic t_largest();
        conv_chk("R3", 6'b0_110_11, 224, 0, 0);
        conv_chk("R3", 6'b1_110_11, -224, 0, 0);
    endtask

    task automatic t_inf();
        conv_chk("R4", 6'b0_111_00, 255, 1, 0);
        conv_chk("R4", 6'b1_111_00, -255, 1, 0);
    endtask

    task automatic t_nan();
        conv_chk("R5", 6'b0_111_01, 0, 0, 1);
        conv_chk("R5", 6'b1_111_10, 0, 0, 1);
        conv_chk("R5", 6'b0_111_11, 0, 0, 1);
    endtask

    task automatic t_sign();
        conv_chk("R6", 6'b1_000_00, 0, 0, 0);
        conv_chk("R6", 6'b1_000_01, -1, 0, 0);
        conv_chk("R6", 6'b1_011_01, -20, 0, 0);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 64; i++) begin
            logic [5:0] c;
            c = 6'(i);
            send(c);
            chk("R2", $sformatf("sweep code %0d", i), int'(out_fx), ref_fx(c));
        end
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_code = 6'b0_100_00;
        in_vld  = 1'b1;
        #1;
        chk("R7", "vld before edge", int'(out_vld), 0);
        chk("R7", "fx before edge", int'(out_fx), ref_fx(6'b1_111_11));
        @(negedge clk);
        chk("R7", "vld after edge", int'(out_vld), 1);
        chk("R7", "fx after edge", int'(out_fx), 32);
        in_code = 6'b0_100_01;
        @(negedge clk);
        chk("R7", "back-to-back vld", int'(out_vld), 1);
        chk("R7", "back-to-back fx", int'(out_fx), 40);
        in_vld = 1'b0;
        @(negedge clk);
        chk("R7", "vld drops", int'(out_vld), 0);
    endtask

    task automatic t_hold();
        send(6'b0_101_10);
        chk("R8", "loaded value", int'(out_fx), 96);
        in_code = 6'b1_111_00;
        repeat (3) @(negedge clk);
        chk("R8", "value held", int'(out_fx), 96);
        chk("R8", "inf held low", int'(out_inf), 0);
        chk("R8", "vld low", int'(out_vld), 0);
        in_code = 6'b0_111_01;
        repeat (2) @(negedge clk);
        chk("R8", "nan held low", int'(out_nan), 0);
        send(6'b0_111_00);
        in_code = 6'b0_000_01;
        repeat (2) @(negedge clk);
        chk("R8", "inf flag held", int'(out_inf), 1);
        chk("R8", "sat held", int'(out_fx), 255);
    endtask

    task automatic t_reset_mid();
        send(6'b1_110_11);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "fx after reset", int'(out_fx), 0);
        chk("R9", "vld after reset", int'(out_vld), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_denorm();
        t_normal();
        t_largest();
        t_inf();
        t_nan();
        t_sign();
        t_sweep();
        send(6'b1_111_11);
        t_latency();
        t_hold();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule